// File: doc/BRIEF.md
# PLL control register file

This block is the software-visible register file that sits in front of a PLL core. It sits on a simple 32-bit register bus. A write is one cycle with `bus_wr` high, and read data follows the address combinationally. The block holds the control, frequency and divider settings the core needs, a read-only configuration word, and up to sixteen output-divider control registers.

Writes are protected by a two-key unlock. Until the first key and then the second key have been written with their magic values, every other register ignores writes. Reads still return their contents.

Two behavioural models stand in for the analog core. One raises the lock status a parameterised number of cycles after the PLL runs enabled and out of bypass. The other raises a calibration lock a fixed number of cycles after calibration is started.

Top module: `pll_regfile`

## Requirements
- R1: Reset leaves the block locked (`unlocked` = 0). It becomes unlocked when 0x68EF3490 is written at offset 0x10 and the next key write is 0xD172BC5A at offset 0x14.
- R2: A wrong value written to either key offset locks the block again. A correct second key without a correct first key just before it does not unlock.
- R3: While locked, writes to every offset other than the two keys are discarded, and reads return register contents unchanged.
- R4: Control at 0x20 keeps bit 31 (bypass), bit 15 (enable) and bit 1 (modulator enable), and resets to 0x80000000. Integer feedback at 0x30 keeps 12 bits and fractional feedback at 0x34 keeps bits 23:0, both resetting to 0. The reference divider at 0x38 keeps bits 5:0 and resets to 1. Unstored bits and unmapped offsets read 0.
- R5: Calibration control at 0x60 is write-only and reads 0. The key offsets also read 0.
- R6: Configuration at 0x08 is read-only. Bits 1:0 give the core type (parameter) and bit 16+i is set when output divider i exists.
- R7: Status bit 0 at 0x24 (and `pll_lock`) goes high exactly LOCK_CYCLES clock edges after the edge that makes enable=1 and bypass=0 take effect.
- R8: Lock drops in the same cycle that the control register shows bypass set or enable cleared.
- R9: A write to 0x60 with bit 31 = 1 and bit 15 = 0 raises calibration lock (bit 31 at 0x64, port `cal_lock`) exactly CAL_CYCLES edges after the write edge. Any other write to 0x60 clears it at once.
- R10: Output divider i sits at 0x80+4*i and keeps bits 15:0. Its bit 15 drives `clkout_en[i]`. For an absent divider, writes are discarded and reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| unlocked | output | 1 | Writes are currently accepted |
| pll_lock | output | 1 | Modelled PLL lock |
| cal_lock | output | 1 | Modelled calibration lock |
| clkout_en | output | NUM_DIV | Clock-output enable for each divider |

## Verification
The assertions assume that `bus_addr` is word aligned and that `bus_wr` is a clean single-cycle pulse held stable around the clock edge. They also assume the bus never writes a key and another register in the same cycle. The stimulus drives every input on the falling edge and issues one transaction per cycle, so these assumptions hold. The sweep runs across all sixteen divider slots on a small configuration with only some dividers present. The lock models are set to short windows, so the bench can count exact edges around both rising lock events.

// File: rtl/pll_regs_pkg.sv
package pll_regs_pkg;
    localparam logic [7:0] OFS_CFG  = 8'h08;
    localparam logic [7:0] OFS_KEY0 = 8'h10;
    localparam logic [7:0] OFS_KEY1 = 8'h14;
    localparam logic [7:0] OFS_CTRL = 8'h20;
    localparam logic [7:0] OFS_STAT = 8'h24;
    localparam logic [7:0] OFS_FINT = 8'h30;
    localparam logic [7:0] OFS_FFRC = 8'h34;
    localparam logic [7:0] OFS_RDIV = 8'h38;
    localparam logic [7:0] OFS_CALC = 8'h60;
    localparam logic [7:0] OFS_CALS = 8'h64;

    localparam logic [31:0] KEY0_VAL = 32'h68EF_3490;
    localparam logic [31:0] KEY1_VAL = 32'hD172_BC5A;

    localparam int CTRL_BYP_BIT = 31;
    localparam int CTRL_EN_BIT  = 15;
    localparam int CTRL_DSM_BIT = 1;
    localparam int CAL_EN_BIT   = 31;
    localparam int CAL_BYP_BIT  = 15;

    localparam int FINT_W = 12;
    localparam int FFRC_W = 24;
    localparam int RDIV_W = 6;
    localparam int ODIV_W = 16;

    typedef struct packed {
        logic              byp;
        logic              en;
        logic              dsm;
        logic [FINT_W-1:0] fint;
        logic [FFRC_W-1:0] ffrc;
        logic [RDIV_W-1:0] rdiv;
    } core_regs_t;
endpackage

// File: rtl/pll_key_gate.sv
module pll_key_gate
    import pll_regs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key0_wr,
    input  logic        key1_wr,
    input  logic [31:0] wdata,
    output logic        unlocked
);
    typedef struct packed {
        logic armed;
        logic open;
    } key_st_t;

    key_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (key0_wr) begin
            st_d.armed = (wdata == KEY0_VAL);
            if (wdata != KEY0_VAL) st_d.open = 1'b0;
        end
        if (key1_wr) begin
            st_d.open  = (wdata == KEY1_VAL) && (st_q.armed || st_q.open);
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign unlocked = st_q.open;
endmodule

// File: rtl/pll_lock_model.sv
module pll_lock_model #(
    parameter int LOCK_CYCLES = 16,
    parameter int CAL_CYCLES  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic cal_wr,
    input  logic cal_go,
    output logic pll_lock,
    output logic cal_lock
);
    localparam int LW = $clog2(LOCK_CYCLES + 1);
    localparam int CW = $clog2(CAL_CYCLES + 1);
    localparam logic [LW-1:0] LMAX = LW'(LOCK_CYCLES);
    localparam logic [CW-1:0] CMAX = CW'(CAL_CYCLES);

    typedef struct packed {
        logic [LW-1:0] lk_cnt;
        logic          cal_run;
        logic [CW-1:0] cal_cnt;
    } lm_st_t;

    lm_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run)                  st_d.lk_cnt = '0;
        else if (st_q.lk_cnt != LMAX) st_d.lk_cnt = st_q.lk_cnt + 1'b1;

        if (cal_wr) begin
            st_d.cal_run = cal_go;
            st_d.cal_cnt = '0;
        end else if (st_q.cal_run && st_q.cal_cnt != CMAX) begin
            st_d.cal_cnt = st_q.cal_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pll_lock = run && (st_q.lk_cnt == LMAX);
    assign cal_lock = st_q.cal_run && (st_q.cal_cnt == CMAX);
endmodule

// File: rtl/pll_div_bank.sv
module pll_div_bank
    import pll_regs_pkg::*;
#(
    parameter int                 NUM_DIV     = 16,
    parameter logic [NUM_DIV-1:0] DIV_PRESENT = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [3:0]        idx,
    input  logic [ODIV_W-1:0] wdata,
    output logic [ODIV_W-1:0] rd_val,
    output logic [NUM_DIV-1:0] clkout_en
);
    logic [ODIV_W-1:0] dv [NUM_DIV];

    for (genvar i = 0; i < NUM_DIV; i++) begin : g_div
        if (DIV_PRESENT[i]) begin : g_on
            logic [ODIV_W-1:0] dv_d, dv_q;
            always_comb dv_d = (wr && idx == 4'(i)) ? wdata : dv_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) dv_q <= '0;
                else        dv_q <= dv_d;
            end
            assign dv[i] = dv_q;
        end else begin : g_off
            assign dv[i] = '0;
        end
        assign clkout_en[i] = dv[i][ODIV_W-1];
    end

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NUM_DIV; i++)
            if (idx == 4'(i)) rd_val = dv[i];
    end
endmodule

// File: rtl/pll_regfile.sv
module pll_regfile
    import pll_regs_pkg::*;
#(
    parameter int                 NUM_DIV     = 16,
    parameter logic [NUM_DIV-1:0] DIV_PRESENT = '1,
    parameter logic [1:0]         PLL_TYPE    = 2'd1,
    parameter int                 LOCK_CYCLES = 16,
    parameter int                 CAL_CYCLES  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [7:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               unlocked,
    output logic               pll_lock,
    output logic               cal_lock,
    output logic [NUM_DIV-1:0] clkout_en
);
    localparam logic [15:0] PRESENT16 = 16'(DIV_PRESENT);
    localparam logic [31:0] CFG_WORD  = {PRESENT16, 14'd0, PLL_TYPE};

    core_regs_t r_d, r_q;

    logic              wr_ok;
    logic              div_hit;
    logic [ODIV_W-1:0] div_rd;
    logic              ctl_en, ctl_byp;
    logic [FINT_W-1:0] fb_int;

    assign wr_ok   = bus_wr && unlocked;
    assign div_hit = (bus_addr[7:6] == 2'b10) && (bus_addr[1:0] == 2'b00);
    assign ctl_en  = r_q.en;
    assign ctl_byp = r_q.byp;
    assign fb_int  = r_q.fint;

    pll_key_gate u_keys (
        .clk      (clk),
        .rst_n    (rst_n),
        .key0_wr  (bus_wr && bus_addr == OFS_KEY0),
        .key1_wr  (bus_wr && bus_addr == OFS_KEY1),
        .wdata    (bus_wdata),
        .unlocked (unlocked)
    );

    pll_lock_model #(
        .LOCK_CYCLES (LOCK_CYCLES),
        .CAL_CYCLES  (CAL_CYCLES)
    ) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (r_q.en && !r_q.byp),
        .cal_wr   (wr_ok && bus_addr == OFS_CALC),
        .cal_go   (bus_wdata[CAL_EN_BIT] && !bus_wdata[CAL_BYP_BIT]),
        .pll_lock (pll_lock),
        .cal_lock (cal_lock)
    );

    pll_div_bank #(
        .NUM_DIV     (NUM_DIV),
        .DIV_PRESENT (DIV_PRESENT)
    ) u_divs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (wr_ok && div_hit),
        .idx       (bus_addr[5:2]),
        .wdata     (bus_wdata[ODIV_W-1:0]),
        .rd_val    (div_rd),
        .clkout_en (clkout_en)
    );

    always_comb begin
        r_d = r_q;
        if (wr_ok) begin
            case (bus_addr)
                OFS_CTRL: begin
                    r_d.byp = bus_wdata[CTRL_BYP_BIT];
                    r_d.en  = bus_wdata[CTRL_EN_BIT];
                    r_d.dsm = bus_wdata[CTRL_DSM_BIT];
                end
                OFS_FINT: r_d.fint = bus_wdata[FINT_W-1:0];
                OFS_FFRC: r_d.ffrc = bus_wdata[FFRC_W-1:0];
                OFS_RDIV: r_d.rdiv = bus_wdata[RDIV_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.byp  <= 1'b1;
            r_q.rdiv <= RDIV_W'(1);
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_CFG:  bus_rdata = CFG_WORD;
            OFS_CTRL: bus_rdata = {r_q.byp, 15'd0, r_q.en, 13'd0, r_q.dsm, 1'b0};
            OFS_STAT: bus_rdata = {31'd0, pll_lock};
            OFS_FINT: bus_rdata = {{(32-FINT_W){1'b0}}, r_q.fint};
            OFS_FFRC: bus_rdata = {{(32-FFRC_W){1'b0}}, r_q.ffrc};
            OFS_RDIV: bus_rdata = {{(32-RDIV_W){1'b0}}, r_q.rdiv};
            OFS_CALS: bus_rdata = {cal_lock, 31'd0};
            default:  bus_rdata = div_hit ? {{(32-ODIV_W){1'b0}}, div_rd} : 32'd0;
        endcase
    end
endmodule

// File: rtl/pll_regfile_chk.sv
module pll_regfile_chk
    import pll_regs_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [7:0]        bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              unlocked,
    input logic              pll_lock,
    input logic              ctl_en,
    input logic              ctl_byp,
    input logic [FINT_W-1:0] fb_int
);
    // R1: unlocking only follows a correct second-key write
    a_r1_unlock_by_key1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(bus_wr && bus_addr == OFS_KEY1 && bus_wdata == KEY1_VAL));

    // R3: locked writes leave the integer feedback untouched
    a_r3_locked_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !unlocked && bus_addr == OFS_FINT) |=> $stable(fb_int));

    // R5: calibration control never reads back
    a_r5_cal_ctrl_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_CALC) |-> (bus_rdata == 32'd0));

    // R7: lock rises only after the core was running
    a_r7_lock_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_lock) |-> $past(ctl_en && !ctl_byp));

    // R8: no lock while bypassed or disabled
    a_r8_lock_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_byp || !ctl_en) |-> !pll_lock);
endmodule

bind pll_regfile pll_regfile_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .unlocked  (unlocked),
    .pll_lock  (pll_lock),
    .ctl_en    (ctl_en),
    .ctl_byp   (ctl_byp),
    .fb_int    (fb_int)
);

// File: tb/pll_regfile_tb.sv
`timescale 1ns/1ps
module pll_regfile_tb;
    localparam int         NDIV = 4;
    localparam logic [3:0] PRES = 4'b0101;
    localparam int         LCYC = 5;
    localparam int         CCYC = 3;
    localparam logic [31:0] K0 = 32'h68EF_3490;
    localparam logic [31:0] K1 = 32'hD172_BC5A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        unlocked, pll_lock, cal_lock;
    logic [NDIV-1:0] clkout_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pll_regfile #(
        .NUM_DIV (NDIV), .DIV_PRESENT (PRES), .PLL_TYPE (2'd1),
        .LOCK_CYCLES (LCYC), .CAL_CYCLES (CCYC)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .unlocked (unlocked),
        .pll_lock (pll_lock), .cal_lock (cal_lock), .clkout_en (clkout_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        chk("R1 reset locked", 32'(unlocked), 32'd0);
        rdchk("R4 ctrl reset", 8'h20, 32'h8000_0000);
        rdchk("R4 refdiv reset", 8'h38, 32'd1);
        rdchk("R7 status reset", 8'h24, 32'd0);
        rdchk("R6 config", 8'h08, 32'h0005_0001);

        // locked writes discarded
        wr(8'h30, 32'h123);
        rdchk("R3 locked write", 8'h30, 32'd0);
        wr(8'h80, 32'hFFFF);
        chk("R3 locked div write", 32'(clkout_en), 32'd0);

        // key sequences
        wr(8'h14, K1);
        chk("R2 key1 alone", 32'(unlocked), 32'd0);
        wr(8'h10, K0); wr(8'h14, K1 ^ 32'h1);
        chk("R2 bad key1", 32'(unlocked), 32'd0);
        wr(8'h10, K0); wr(8'h10, K0 ^ 32'h4); wr(8'h14, K1);
        chk("R2 bad key0 between", 32'(unlocked), 32'd0);
        wr(8'h10, K0); wr(8'h14, K1);
        chk("R1 unlock", 32'(unlocked), 32'd1);
        rdchk("R5 key0 reads zero", 8'h10, 32'd0);
        rdchk("R5 key1 reads zero", 8'h14, 32'd0);

        // field widths, several patterns
        for (int p = 0; p < 4; p++) begin
            logic [31:0] pat;
            pat = (p == 0) ? 32'hFFFF_FFFF : (p == 1) ? 32'hA5A5_A5A5 :
                  (p == 2) ? 32'h5A5A_5A5A : 32'h0000_0001;
            wr(8'h30, pat); rdchk("R4 fint", 8'h30, pat & 32'h0000_0FFF);
            wr(8'h34, pat); rdchk("R4 ffrac", 8'h34, pat & 32'h00FF_FFFF);
            wr(8'h38, pat); rdchk("R4 refdiv", 8'h38, pat & 32'h0000_003F);
        end
        wr(8'h20, 32'hFFFF_FFFF);
        rdchk("R4 ctrl mask", 8'h20, 32'h8000_8002);
        rdchk("R4 unmapped", 8'h40, 32'd0);
        wr(8'h08, 32'd0);
        rdchk("R6 config read-only", 8'h08, 32'h0005_0001);

        // divider sweep over all sixteen slots
        for (int i = 0; i < 16; i++) begin
            logic [31:0] expv;
            wr(8'h80 + 8'(4 * i), 32'hFFFF_8000 | 32'(i));
            expv = (i < NDIV && PRES[i % NDIV]) ? (32'h8000 | 32'(i)) : 32'd0;
            rdchk("R10 divider slot", 8'h80 + 8'(4 * i), expv);
        end
        chk("R10 clkout_en", 32'(clkout_en), 32'(PRES));
        wr(8'h80, 32'h0);
        chk("R10 clkout_en cleared", 32'(clkout_en), 32'h4);

        // calibration
        wr(8'h60, 32'h8012_0000);
        repeat (CCYC - 1) @(negedge clk);
        chk("R9 cal lock early", 32'(cal_lock), 32'd0);
        @(negedge clk);
        chk("R9 cal lock on time", 32'(cal_lock), 32'd1);
        rdchk("R9 cal status", 8'h64, 32'h8000_0000);
        rdchk("R5 cal ctrl reads zero", 8'h60, 32'd0);
        wr(8'h60, 32'h8012_8000);
        chk("R9 cal bypass clears", 32'(cal_lock), 32'd0);
        repeat (CCYC + 2) @(negedge clk);
        chk("R9 cal stays clear", 32'(cal_lock), 32'd0);

        // PLL lock timing
        wr(8'h20, 32'h8000_8000);
        chk("R8 no lock in bypass", 32'(pll_lock), 32'd0);
        wr(8'h20, 32'h0000_8000);
        repeat (LCYC - 1) @(negedge clk);
        chk("R7 lock early", 32'(pll_lock), 32'd0);
        @(negedge clk);
        chk("R7 lock on time", 32'(pll_lock), 32'd1);
        rdchk("R7 status bit", 8'h24, 32'd1);
        wr(8'h20, 32'h8000_8000);
        chk("R8 bypass drops lock", 32'(pll_lock), 32'd0);
        wr(8'h20, 32'h0000_8000);
        repeat (LCYC + 1) @(negedge clk);
        chk("R7 relock", 32'(pll_lock), 32'd1);
        wr(8'h20, 32'h0000_0000);
        chk("R8 disable drops lock", 32'(pll_lock), 32'd0);

        // relock the register file
        wr(8'h10, 32'h0);
        chk("R2 wrong key0 locks", 32'(unlocked), 32'd0);
        wr(8'h30, 32'h5);
        rdchk("R3 write after relock", 8'h30, 32'h001);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule